// File: doc/BRIEF.md
# Grouped Maskable Interrupt Controller

The controller gathers interrupt sources into five groups of up to 32 lines each. Not every bit position is wired: each group has a fixed set of implemented bits, and unimplemented bits never show as pending. Software reads a pending word and reads or writes a mask word for each group over a small word-addressed register port. A source counts as active when it is pending and its mask bit is clear. Each group raises its own CPU interrupt line while it has an active source. Group g drives line g+2, so the five group lines occupy positions 2 to 6 of an 8-bit line vector.

A registered priority encoder picks one winner. A dedicated top-priority input on line 7 beats everything. Without it, the highest-numbered active group wins, and within that group the highest-numbered active bit wins. The encoder reports the group, the bit and a flat interrupt number equal to group*32 + bit + 8. The last group carries general-purpose I/O sources. Its lowest 14 lines have a programmable polarity and a sticky status bit that software can clear.

Top module: `grp_irq_ctrl`

## Requirements
- R1: After reset:
  - every mask register reads 0xFFFFFFFF;
  - cpu_line_o[6:2] is 0;
  - win_vld_o is 0;
  - the polarity register reads 0x00003FFF;
  - the status register reads 0.
- R2: Reading word address 4*g returns the pending word of group g. Bit b of that word equals the current level of source src_i[32*g+b], after any polarity adjustment, ANDed with the group's implemented-bit mask. The implemented-bit masks for groups 0 to 4 are 0x0000EFFF, 0x00001FFF, 0x00000007, 0x0003FFFF and 0xFFFFFFFF. Pending bits are not latched.
- R3: Word address 4*g+2 is the mask register of group g. A write changes only implemented bits, and unimplemented bits stay 1. A bit value of 1 blocks the source.
- R4: cpu_line_o[g+2] is 1 exactly when group g has a pending bit whose mask bit is 0. cpu_line_o[1:0] is 0. cpu_line_o[7] follows top_irq_i. These outputs respond in the same cycle as their inputs.
- R5: One clock after the inputs settle, the encoder reports the highest-numbered group with an active source in win_grp_o. It reports the highest-numbered active bit of that group in win_bit_o, and win_top_o is 0.
- R6: win_num_o equals win_grp_o*32 + win_bit_o + 8. win_vld_o is 0 when no group is active and top_irq_i is low.
- R7: While top_irq_i is 1, the next cycle shows:
  - win_vld_o=1 and win_top_o=1;
  - win_num_o=7;
  - win_grp_o=0 and win_bit_o=0.

  This holds whatever the group activity.
- R8: Word address 17 is the polarity register of group 4. For lines 0 to 13, bit i=1 means active high and bit i=0 means active low, in which case the pending bit is the inverted source. Bits 14 to 31 are not writable and read 0.
- R9: Word address 19 is the status register of group 4.
  - A bit i (i<14) is set in every cycle that the polarity-adjusted line is active, regardless of the mask.
  - The bit stays set after the line drops.
  - A write clears the bits written as 0 and leaves the bits written as 1 unchanged.
  - Bits 14 to 31 read 0.
- R10: Word addresses 4*g+1 and 4*g+3 for groups 0 to 3, and all addresses of 20 and above, read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_i | input | 160 | Source levels; bit 32*g+b is group g, bit b |
| top_irq_i | input | 1 | Top-priority interrupt request (line 7) |
| addr_i | input | 5 | Register word address |
| we_i | input | 1 | Register write enable |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data, combinational from addr_i |
| cpu_line_o | output | 8 | CPU interrupt lines; bits 2..6 groups, bit 7 top request |
| win_vld_o | output | 1 | Encoder result valid (registered) |
| win_top_o | output | 1 | Winner is the top-priority line |
| win_grp_o | output | 3 | Winning group index |
| win_bit_o | output | 5 | Winning bit within the group |
| win_num_o | output | 8 | Flat interrupt number |

## Verification
Every one of the 160 source positions is raised alone with all masks clear. This separates implemented from unimplemented bits and confirms the group-to-line mapping and the number arithmetic at every position. Pairs of sources in different groups, and in one group at its lowest and highest bits, show that the higher index wins rather than the first-found one. Re-masking a raised source and asserting the top request while groups are active separate blocking and override from plain level reporting. Inverted polarity with a low source, and status bits written with mixed ones and zeros after the line drops, distinguish sticky clear-by-zero behaviour from a level copy.

// File: rtl/grp_irq_pkg.sv
package grp_irq_pkg;
  localparam int unsigned GRP_MAX_W = 32;

  // implemented source bits per group
  function automatic logic [GRP_MAX_W-1:0] impl_bits(input int unsigned g);
    case (g)
      0:       impl_bits = 32'h0000_EFFF;
      1:       impl_bits = 32'h0000_1FFF;
      2:       impl_bits = 32'h0000_0007;
      3:       impl_bits = 32'h0003_FFFF;
      default: impl_bits = 32'hFFFF_FFFF;
    endcase
  endfunction

  typedef enum logic [1:0] {
    OFS_PEND = 2'd0,
    OFS_POL  = 2'd1,
    OFS_MASK = 2'd2,
    OFS_STAT = 2'd3
  } reg_ofs_e;
endpackage

// File: rtl/grp_irq_bank.sv
module grp_irq_bank #(
  parameter int unsigned GRP_W = 32,
  parameter logic [GRP_W-1:0] IMPL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [GRP_W-1:0] lvl_i,
  input  logic             mask_we_i,
  input  logic [GRP_W-1:0] wdata_i,
  output logic [GRP_W-1:0] pend_o,
  output logic [GRP_W-1:0] mask_o,
  output logic             act_any_o,
  output logic [GRP_W-1:0] act_o
);
  logic [GRP_W-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mask_q <= '1;
    else if (mask_we_i) mask_q <= (mask_q & ~IMPL) | (wdata_i & IMPL);
  end

  assign pend_o    = lvl_i & IMPL;
  assign mask_o    = mask_q;
  assign act_o     = pend_o & ~mask_q;
  assign act_any_o = |act_o;
endmodule

// File: rtl/grp_irq_gpio.sv
module grp_irq_gpio #(
  parameter int unsigned GRP_W  = 32,
  parameter int unsigned GPIO_N = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [GRP_W-1:0]  raw_i,
  input  logic              pol_we_i,
  input  logic              stat_we_i,
  input  logic [GPIO_N-1:0] wdata_i,
  output logic [GRP_W-1:0]  lvl_o,
  output logic [GRP_W-1:0]  pol_o,
  output logic [GRP_W-1:0]  stat_o
);
  logic [GPIO_N-1:0] pol_q, stat_q, hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pol_q <= '1;
    else if (pol_we_i) pol_q <= wdata_i;
  end

  assign hit = lvl_o[GPIO_N-1:0];

  // set wins over clear while the line is still active
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= (stat_q & (stat_we_i ? wdata_i : '1)) | hit;
  end

  for (genvar i = 0; i < GRP_W; i++) begin : g_line
    if (i < GPIO_N) begin : g_pol
      assign lvl_o[i]  = raw_i[i] ~^ pol_q[i];
      assign pol_o[i]  = pol_q[i];
      assign stat_o[i] = stat_q[i];
    end else begin : g_plain
      assign lvl_o[i]  = raw_i[i];
      assign pol_o[i]  = 1'b0;
      assign stat_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/grp_irq_enc.sv
module grp_irq_enc #(
  parameter int unsigned NUM_GRP  = 5,
  parameter int unsigned GRP_W    = 32,
  parameter int unsigned NUM_BASE = 8,
  parameter int unsigned TOP_NUM  = 7,
  localparam int unsigned GI_W    = $clog2(NUM_GRP),
  localparam int unsigned BI_W    = $clog2(GRP_W),
  localparam int unsigned NUM_W   = $clog2(NUM_GRP*GRP_W+NUM_BASE+1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_GRP*GRP_W-1:0] act_i,
  input  logic [NUM_GRP-1:0]       grp_any_i,
  input  logic                     top_i,
  output logic                     vld_o,
  output logic                     top_o,
  output logic [GI_W-1:0]          grp_o,
  output logic [BI_W-1:0]          bit_o,
  output logic [NUM_W-1:0]         num_o
);
  logic [GI_W-1:0]  g_sel;
  logic [BI_W-1:0]  b_sel;
  logic [GRP_W-1:0] row;
  logic             any;
  logic [NUM_W-1:0] num_c;

  // ascending scans: the last hit, i.e. the highest index, wins
  always_comb begin
    g_sel = '0;
    any   = 1'b0;
    for (int g = 0; g < NUM_GRP; g++) begin
      if (grp_any_i[g]) begin
        g_sel = GI_W'(g);
        any   = 1'b1;
      end
    end
    row   = act_i[int'(g_sel)*GRP_W +: GRP_W];
    b_sel = '0;
    for (int b = 0; b < GRP_W; b++) begin
      if (row[b]) b_sel = BI_W'(b);
    end
    num_c = NUM_W'(int'(g_sel)*GRP_W + int'(b_sel) + NUM_BASE);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o <= 1'b0;
      top_o <= 1'b0;
      grp_o <= '0;
      bit_o <= '0;
      num_o <= '0;
    end else if (top_i) begin
      vld_o <= 1'b1;
      top_o <= 1'b1;
      grp_o <= '0;
      bit_o <= '0;
      num_o <= NUM_W'(TOP_NUM);
    end else begin
      vld_o <= any;
      top_o <= 1'b0;
      grp_o <= any ? g_sel : '0;
      bit_o <= any ? b_sel : '0;
      num_o <= any ? num_c : '0;
    end
  end
endmodule

// File: rtl/grp_irq_ctrl.sv
module grp_irq_ctrl #(
  parameter int unsigned NUM_GRP  = 5,
  parameter int unsigned GRP_W    = 32,
  parameter int unsigned GPIO_GRP = 4,
  parameter int unsigned GPIO_N   = 14,
  parameter int unsigned LINE_OFS = 2,
  parameter int unsigned NUM_BASE = 8,
  parameter int unsigned TOP_NUM  = 7,
  localparam int unsigned SRC_W   = NUM_GRP*GRP_W,
  localparam int unsigned ADDR_W  = $clog2(NUM_GRP*4),
  localparam int unsigned LINE_W  = LINE_OFS+NUM_GRP+1,
  localparam int unsigned GI_W    = $clog2(NUM_GRP),
  localparam int unsigned BI_W    = $clog2(GRP_W),
  localparam int unsigned NUM_W   = $clog2(NUM_GRP*GRP_W+NUM_BASE+1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SRC_W-1:0]  src_i,
  input  logic              top_irq_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [GRP_W-1:0]  wdata_i,
  output logic [GRP_W-1:0]  rdata_o,
  output logic [LINE_W-1:0] cpu_line_o,
  output logic              win_vld_o,
  output logic              win_top_o,
  output logic [GI_W-1:0]   win_grp_o,
  output logic [BI_W-1:0]   win_bit_o,
  output logic [NUM_W-1:0]  win_num_o
);
  import grp_irq_pkg::*;

  localparam int unsigned AG_W = ADDR_W-2;

  logic [AG_W-1:0]  a_grp;
  logic [1:0]       a_ofs;
  logic [GRP_W-1:0] pend_a [NUM_GRP];
  logic [GRP_W-1:0] mask_a [NUM_GRP];
  logic [NUM_GRP-1:0] grp_act;
  logic [SRC_W-1:0] act_flat;
  logic [GRP_W-1:0] gpio_pol, gpio_stat;

  assign a_grp = addr_i[ADDR_W-1:2];
  assign a_ofs = addr_i[1:0];

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    logic [GRP_W-1:0] lvl;
    logic             sel;
    assign sel = we_i && (int'(a_grp) == g);

    if (g == GPIO_GRP) begin : g_gpio
      grp_irq_gpio #(.GRP_W(GRP_W), .GPIO_N(GPIO_N)) u_gpio (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .raw_i     (src_i[g*GRP_W +: GRP_W]),
        .pol_we_i  (sel && a_ofs == OFS_POL),
        .stat_we_i (sel && a_ofs == OFS_STAT),
        .wdata_i   (wdata_i[GPIO_N-1:0]),
        .lvl_o     (lvl),
        .pol_o     (gpio_pol),
        .stat_o    (gpio_stat)
      );
    end else begin : g_plain
      assign lvl = src_i[g*GRP_W +: GRP_W];
    end

    grp_irq_bank #(.GRP_W(GRP_W), .IMPL(impl_bits(g))) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .lvl_i     (lvl),
      .mask_we_i (sel && a_ofs == OFS_MASK),
      .wdata_i   (wdata_i),
      .pend_o    (pend_a[g]),
      .mask_o    (mask_a[g]),
      .act_any_o (grp_act[g]),
      .act_o     (act_flat[g*GRP_W +: GRP_W])
    );
  end

  always_comb begin
    rdata_o = '0;
    for (int g = 0; g < NUM_GRP; g++) begin
      if (int'(a_grp) == g) begin
        case (a_ofs)
          OFS_PEND: rdata_o = pend_a[g];
          OFS_MASK: rdata_o = mask_a[g];
          OFS_POL:  if (g == GPIO_GRP) rdata_o = gpio_pol;
          OFS_STAT: if (g == GPIO_GRP) rdata_o = gpio_stat;
          default:  rdata_o = '0;
        endcase
      end
    end
  end

  always_comb begin
    cpu_line_o = '0;
    for (int g = 0; g < NUM_GRP; g++) cpu_line_o[g+LINE_OFS] = grp_act[g];
    cpu_line_o[LINE_W-1] = top_irq_i;
  end

  grp_irq_enc #(
    .NUM_GRP(NUM_GRP), .GRP_W(GRP_W), .NUM_BASE(NUM_BASE), .TOP_NUM(TOP_NUM)
  ) u_enc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .act_i     (act_flat),
    .grp_any_i (grp_act),
    .top_i     (top_irq_i),
    .vld_o     (win_vld_o),
    .top_o     (win_top_o),
    .grp_o     (win_grp_o),
    .bit_o     (win_bit_o),
    .num_o     (win_num_o)
  );
endmodule

// File: rtl/grp_irq_chk.sv
module grp_irq_chk #(
  parameter int unsigned NUM_GRP  = 5,
  parameter int unsigned GRP_W    = 32,
  parameter int unsigned LINE_OFS = 2,
  parameter int unsigned NUM_BASE = 8,
  parameter int unsigned TOP_NUM  = 7,
  parameter int unsigned ADDR_W   = 5,
  parameter int unsigned LINE_W   = 8,
  parameter int unsigned GI_W     = 3,
  parameter int unsigned BI_W     = 5,
  parameter int unsigned NUM_W    = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              top_irq_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              we_i,
  input logic [GRP_W-1:0]  wdata_i,
  input logic [LINE_W-1:0] cpu_line_o,
  input logic              win_vld_o,
  input logic              win_top_o,
  input logic [GI_W-1:0]   win_grp_o,
  input logic [BI_W-1:0]   win_bit_o,
  input logic [NUM_W-1:0]  win_num_o
);
  p_top_win_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    top_irq_i |=> (win_vld_o && win_top_o && win_num_o == NUM_W'(TOP_NUM)));

  p_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_line_o == '0) |=> !win_vld_o);

  p_grp_lat_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!top_irq_i && cpu_line_o[LINE_OFS +: NUM_GRP] != '0) |=> (win_vld_o && !win_top_o));

  p_num_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_vld_o && !win_top_o) |->
      (int'(win_num_o) == int'(win_grp_o)*GRP_W + int'(win_bit_o) + NUM_BASE));

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_mask
    p_mask_block_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && int'(addr_i) == 4*g+2 && wdata_i == '1) |=> !cpu_line_o[g+LINE_OFS]);
  end
endmodule

bind grp_irq_ctrl grp_irq_chk #(
  .NUM_GRP(NUM_GRP), .GRP_W(GRP_W), .LINE_OFS(LINE_OFS), .NUM_BASE(NUM_BASE),
  .TOP_NUM(TOP_NUM), .ADDR_W(ADDR_W), .LINE_W(LINE_W), .GI_W(GI_W),
  .BI_W(BI_W), .NUM_W(NUM_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .top_irq_i  (top_irq_i),
  .addr_i     (addr_i),
  .we_i       (we_i),
  .wdata_i    (wdata_i),
  .cpu_line_o (cpu_line_o),
  .win_vld_o  (win_vld_o),
  .win_top_o  (win_top_o),
  .win_grp_o  (win_grp_o),
  .win_bit_o  (win_bit_o),
  .win_num_o  (win_num_o)
);

// File: tb/sim_grp_irq_ctrl.sv
`timescale 1ns/1ps
module sim_grp_irq_ctrl;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [159:0] src = '0;
  logic         top = 1'b0;
  logic [4:0]   addr = '0;
  logic         we = 1'b0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic [7:0]   line;
  logic         vld, wtop;
  logic [2:0]   wgrp;
  logic [4:0]   wbit;
  logic [7:0]   wnum;

  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  grp_irq_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .top_irq_i(top),
    .addr_i(addr), .we_i(we), .wdata_i(wdata), .rdata_o(rdata),
    .cpu_line_o(line), .win_vld_o(vld), .win_top_o(wtop),
    .win_grp_o(wgrp), .win_bit_o(wbit), .win_num_o(wnum)
  );

  function automatic logic [31:0] impl(input int g);
    case (g)
      0: return 32'h0000_EFFF;
      1: return 32'h0000_1FFF;
      2: return 32'h0000_0007;
      3: return 32'h0003_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk);
    #1 we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    addr = a;
    #0.5 d = rdata;
  endtask

  // apply sources at a falling edge, wait for the encoder register
  task automatic apply(input logic [159:0] s, input logic t);
    @(negedge clk);
    src = s; top = t;
    @(posedge clk);
    #1;
  endtask

  task automatic chk_win(input string req, input int g, input int b);
    chk(req, {31'd0, vld}, 32'd1);
    chk(req, {31'd0, wtop}, 32'd0);
    chk(req, {29'd0, wgrp}, g);
    chk(req, {27'd0, wbit}, b);
    chk(req, {24'd0, wnum}, g*32 + b + 8);
  endtask

  initial begin : watchdog
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    logic [31:0] d;
    logic [159:0] s;
    #5 rst_n = 1'b1;
    #1;

    // R1 reset state
    for (int g = 0; g < 5; g++) begin
      rd(5'(4*g+2), d);
      chk("R1 mask reset", d, 32'hFFFF_FFFF);
    end
    chk("R1 lines", {24'd0, line}, 32'd0);
    chk("R1 vld", {31'd0, vld}, 32'd0);
    rd(5'd17, d); chk("R1 pol reset", d, 32'h0000_3FFF);
    rd(5'd19, d); chk("R1 stat reset", d, 32'd0);

    // R3 mask write touches implemented bits only
    for (int g = 0; g < 5; g++) begin
      wr(5'(4*g+2), 32'd0);
      rd(5'(4*g+2), d);
      chk("R3 mask write", d, ~impl(g));
    end

    // R2 R4 R5 R6 single-source sweep over every position
    for (int g = 0; g < 5; g++) begin
      for (int b = 0; b < 32; b++) begin
        s = '0;
        s[g*32+b] = 1'b1;
        apply(s, 1'b0);
        rd(5'(4*g), d);
        chk("R2 pending", d, impl(g) & (32'd1 << b));
        if (impl(g)[b]) begin
          chk("R4 line", {24'd0, line}, 32'd1 << (g+2));
          chk_win("R5 R6 single", g, b);
        end else begin
          chk("R4 line idle", {24'd0, line}, 32'd0);
          chk("R6 vld idle", {31'd0, vld}, 32'd0);
        end
      end
    end

    // R5 highest group wins
    s = '0; s[32+3] = 1'b1; s[96+10] = 1'b1;
    apply(s, 1'b0);
    chk_win("R5 groups 1 vs 3", 3, 10);
    chk("R4 two lines", {24'd0, line}, 32'h0000_0028);
    s = '0; s[2] = 1'b1; s[11] = 1'b1;
    apply(s, 1'b0);
    chk_win("R5 bits in group 0", 0, 11);
    s = '0; s[128] = 1'b1; s[159] = 1'b1; s[0] = 1'b1;
    apply(s, 1'b0);
    chk_win("R5 bits in group 4", 4, 31);

    // R2 pending not latched
    apply('0, 1'b0);
    rd(5'd16, d); chk("R2 unlatched", d, 32'd0);
    chk("R6 vld drop", {31'd0, vld}, 32'd0);

    // R3 masking blocks a raised source
    s = '0; s[96+5] = 1'b1; s[32+1] = 1'b1;
    apply(s, 1'b0);
    chk_win("R3 before mask", 3, 5);
    wr(5'd14, 32'h0000_0020);
    #1;
    chk("R3 masked line", {24'd0, line}, 32'h0000_0008);
    apply(s, 1'b0);
    chk_win("R3 after mask", 1, 1);
    wr(5'd14, 32'hFFFF_FFFF);
    rd(5'd14, d); chk("R3 mask all", d, 32'hFFFF_FFFF);
    wr(5'd14, 32'd0);

    // R7 top request overrides group activity
    s = '0; s[150] = 1'b1;
    apply(s, 1'b1);
    chk("R7 vld", {31'd0, vld}, 32'd1);
    chk("R7 top", {31'd0, wtop}, 32'd1);
    chk("R7 num", {24'd0, wnum}, 32'd7);
    chk("R7 grp", {29'd0, wgrp}, 32'd0);
    chk("R7 bit", {27'd0, wbit}, 32'd0);
    chk("R7 line", {24'd0, line}, 32'h0000_0040 | 32'h0000_0080);
    apply(s, 1'b0);
    chk_win("R7 release", 4, 22);
    apply('0, 1'b0);

    // R8 polarity
    wr(5'd17, 32'hFFFF_FFF7);
    rd(5'd17, d); chk("R8 pol read", d, 32'h0000_3FF7);
    rd(5'd16, d); chk("R8 low active", d, 32'h0000_0008);
    chk("R8 line", {24'd0, line}, 32'h0000_0040);
    s = '0; s[131] = 1'b1;
    apply(s, 1'b0);
    rd(5'd16, d); chk("R8 inverted high", d, 32'd0);
    wr(5'd17, 32'hFFFF_FFFF);
    apply('0, 1'b0);
    rd(5'd16, d); chk("R8 restored", d, 32'd0);

    // R9 status sticky and clear-by-zero
    wr(5'd19, 32'd0);
    rd(5'd19, d); chk("R9 cleared", d, 32'd0);
    s = '0; s[133] = 1'b1; s[148] = 1'b1;
    apply(s, 1'b0);
    apply('0, 1'b0);
    rd(5'd19, d); chk("R9 sticky", d, 32'h0000_0020);
    wr(5'd19, 32'hFFFF_FFFF);
    rd(5'd19, d); chk("R9 write one", d, 32'h0000_0020);
    wr(5'd19, 32'hFFFF_FFDF);
    rd(5'd19, d); chk("R9 write zero", d, 32'd0);
    wr(5'd14, 32'hFFFF_FFFF);
    wr(5'd18, 32'hFFFF_FFFF);
    s = '0; s[135] = 1'b1;
    apply(s, 1'b0);
    rd(5'd19, d); chk("R9 masked still sets", d, 32'h0000_0080);
    apply('0, 1'b0);

    // R10 unmapped reads
    rd(5'd1, d);  chk("R10 grp0 ofs1", d, 32'd0);
    rd(5'd11, d); chk("R10 grp2 ofs3", d, 32'd0);
    rd(5'd20, d); chk("R10 addr 20", d, 32'd0);
    rd(5'd31, d); chk("R10 addr 31", d, 32'd0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule